// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns a single 8-bit rate setting into the bus-clock-accurate line timing an I2C master needs. It drives the SCL and SDA lines as open-drain pull enables: a 1 pulls the line low and a 0 releases it. It runs one operation at a time on request: a START condition, one data bit, or a STOP condition. The surrounding controller handles byte shifting, acknowledge, arbitration and clock stretching. It issues one strobe per operation and waits for the one-cycle completion pulse before it issues the next.

The rate setting has two fields. A 2-bit scale code in bits 7:6 selects a factor of 1, 2 or 4. A 6-bit rate index in bits 5:0 addresses a combinational table. Each table entry gives one SCL divider and three hold figures: data hold, START hold and STOP hold. The scale factor multiplies all four. The hold figures are stored in quarter-clock units, so a scaled hold of `factor × figure / 4` bus clocks, rounded down, can reach odd clock counts such as 41. All figures are captured when an operation is accepted. A change to the setting while an operation runs therefore applies from the next operation on.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is active and in the first cycle after it, `scl_pull`, `sda_pull` and `op_done` are all 0.
- R2: Scale code 00 gives a factor of 1, 01 gives 2 and 10 gives 4. The reserved code 11 behaves exactly like 00.
- R3: A data bit lasts P = factor × divider bus clocks. SCL is pulled low for floor(P/2) clocks, counted from acceptance, and released for the remaining clocks.
- R4: In a data bit or STOP, SDA keeps its previous state for H = floor(factor × data-hold figure / 4) clocks from acceptance, then changes. H is clamped to the range 1 to floor(P/2)−1.
- R5: A START is accepted only while the bus is idle, meaning both lines are released. SDA is pulled low with SCL released for floor(factor × START figure / 4) clocks, minimum 1. Then SCL is pulled low.
- R6: A STOP pulls SDA low after the data hold and releases SCL at the end of the low half. SCL then stays released with SDA low for floor(factor × STOP figure / 4) clocks, minimum 1. After that, both lines are released.
- R7: The table holds these entries (divider, then data-hold, START and STOP figures in quarter clocks): 0x00 = 20/28/38/41, 0x07 = 40/40/68/82, 0x0B = 40/36/64/84, 0x14 = 80/68/128/168, 0x18 = 80/36/96/176. Every other index uses the 0x00 entry.
- R8: `op_done` is high for exactly one cycle, the first cycle after the last timed phase of an operation. A new request is accepted in that cycle.
- R9: Requests that do not fit the current state have no effect. These are a START while SCL is held low, a bit or STOP while idle, and any request during an operation. When bit and STOP are requested together, the STOP wins.
- R10: The timing figures are captured at acceptance. A write to `div_cfg` during an operation does not change that operation.
- R11: With setting 0x80 the START, data and STOP holds are 38, 28 and 41 clocks. With setting 0x18 they are 24, 9 and 44 clocks.
- R12: A data bit pulls SDA low for a 0 and releases it for a 1. SDA keeps that state after the bit until the next operation changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cfg | input | 8 | Rate setting: [7:6] scale code, [5:0] rate index |
| start_req | input | 1 | Request a START condition (one-cycle strobe) |
| bit_req | input | 1 | Request one data bit (one-cycle strobe) |
| stop_req | input | 1 | Request a STOP condition (one-cycle strobe) |
| bit_val | input | 1 | Data bit value, sampled with `bit_req` |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to create from the ports are a rate change that lands in the middle of a bit and a strobe that arrives while a timed phase is still running. Only a precisely placed write or pulse can reach them. The stimulus times `div_cfg` writes and stray strobes a few cycles after an accepted request, and it also issues bit and STOP strobes in the same cycle. A behavioural model captures the setting at acceptance and predicts every cycle of both lines. The two stated configurations are also measured directly as run lengths on the pull outputs.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int IDX_W      = 6;
    localparam int MUL_W      = 2;
    localparam int DIV_W      = 8;
    localparam int HQ_W       = 8;
    localparam int SH_MAX     = 2;
    localparam int CNT_W      = DIV_W + SH_MAX;
    localparam int N_HOLD     = 3;
    localparam int FRAC_BITS  = 2;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [HQ_W-1:0]  dat_q;
        logic [HQ_W-1:0]  sta_q;
        logic [HQ_W-1:0]  sto_q;
    } rate_entry_t;

    typedef struct packed {
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] dat_hold;
        logic [CNT_W-1:0] sta_hold;
        logic [CNT_W-1:0] sto_hold;
    } phase_len_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STA,
        ST_PARK,
        ST_LOW_A,
        ST_LOW_B,
        ST_HIGH
    } seq_state_e;

    typedef struct packed {
        seq_state_e       st;
        logic             is_stop;
        logic             sda_next;
        logic [CNT_W-1:0] cnt;
        phase_len_t       len;
        logic             scl_pull;
        logic             sda_pull;
        logic             done;
    } seq_reg_t;

    function automatic rate_entry_t mk_entry(input int d, input int a, input int s, input int p);
        rate_entry_t e;
        e.div   = DIV_W'(d);
        e.dat_q = HQ_W'(a);
        e.sta_q = HQ_W'(s);
        e.sto_q = HQ_W'(p);
        return e;
    endfunction

endpackage

// File: rtl/i2ct_rate_lut.sv
module i2ct_rate_lut
    import i2ct_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output rate_entry_t      entry
);

    // Divider and quarter-clock hold figures per index (R7)
    always_comb begin
        case (idx)
            IDX_W'(7'h07): entry = mk_entry(40, 40, 68, 82);
            IDX_W'(7'h0B): entry = mk_entry(40, 36, 64, 84);
            IDX_W'(7'h14): entry = mk_entry(80, 68, 128, 168);
            IDX_W'(7'h18): entry = mk_entry(80, 36, 96, 176);
            default:       entry = mk_entry(20, 28, 38, 41);
        endcase
    end

endmodule

// File: rtl/i2ct_scale.sv
module i2ct_scale
    import i2ct_pkg::*;
(
    input  logic [MUL_W-1:0] mul_code,
    input  rate_entry_t      entry,
    output phase_len_t       lens
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [1:0]       sh;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] low_half;
    logic [HQ_W-1:0]  fig [N_HOLD];
    logic [CNT_W-1:0] clk_hold [N_HOLD];

    // scale code to shift amount; reserved code acts as factor 1 (R2)
    always_comb begin
        case (mul_code)
            2'b01:   sh = 2'd1;
            2'b10:   sh = 2'd2;
            default: sh = 2'd0;
        endcase
    end

    assign period   = CNT_W'(entry.div) << sh;
    assign low_half = period >> 1;

    assign fig[0] = entry.dat_q;
    assign fig[1] = entry.sta_q;
    assign fig[2] = entry.sto_q;

    genvar g;
    generate
        for (g = 0; g < N_HOLD; g++) begin : g_hold
            logic [HQ_W+SH_MAX-1:0] prod;
            assign prod        = {{SH_MAX{1'b0}}, fig[g]} << sh;
            assign clk_hold[g] = CNT_W'(prod >> FRAC_BITS);
        end
    endgenerate

    always_comb begin
        lens.low  = low_half;
        lens.high = period - low_half;
        if (clk_hold[0] == '0)
            lens.dat_hold = ONE;
        else if (clk_hold[0] >= low_half)
            lens.dat_hold = low_half - ONE;
        else
            lens.dat_hold = clk_hold[0];
        lens.sta_hold = (clk_hold[1] == '0) ? ONE : clk_hold[1];
        lens.sto_hold = (clk_hold[2] == '0) ? ONE : clk_hold[2];
    end

endmodule

// File: rtl/i2ct_seq.sv
module i2ct_seq
    import i2ct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       bit_req,
    input  logic       stop_req,
    input  logic       bit_val,
    input  phase_len_t lens_in,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    r_d.len      = lens_in;
                    r_d.st       = ST_STA;
                    r_d.cnt      = lens_in.sta_hold - ONE;
                    r_d.sda_pull = 1'b1;
                    r_d.scl_pull = 1'b0;
                end
            end
            ST_STA: begin
                if (r_q.cnt == '0) begin
                    r_d.st       = ST_PARK;
                    r_d.scl_pull = 1'b1;
                    r_d.done     = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            ST_PARK: begin
                if (stop_req || bit_req) begin
                    r_d.len      = lens_in;
                    r_d.is_stop  = stop_req;
                    r_d.sda_next = stop_req ? 1'b1 : ~bit_val;
                    r_d.st       = ST_LOW_A;
                    r_d.cnt      = lens_in.dat_hold - ONE;
                end
            end
            ST_LOW_A: begin
                if (r_q.cnt == '0) begin
                    r_d.st       = ST_LOW_B;
                    r_d.sda_pull = r_q.sda_next;
                    r_d.cnt      = r_q.len.low - r_q.len.dat_hold - ONE;
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            ST_LOW_B: begin
                if (r_q.cnt == '0) begin
                    r_d.st       = ST_HIGH;
                    r_d.scl_pull = 1'b0;
                    r_d.cnt      = r_q.is_stop ? (r_q.len.sto_hold - ONE)
                                               : (r_q.len.high - ONE);
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == '0) begin
                    r_d.done = 1'b1;
                    if (r_q.is_stop) begin
                        r_d.st       = ST_IDLE;
                        r_d.scl_pull = 1'b0;
                        r_d.sda_pull = 1'b0;
                    end else begin
                        r_d.st       = ST_PARK;
                        r_d.scl_pull = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_pull = r_q.scl_pull;
    assign sda_pull = r_q.sda_pull;
    assign done     = r_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_SCL_AT_PHASE_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_pull) |-> ($past(r_q.cnt) == '0)); // R3

    AST_DATA_EDGE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && $past(scl_pull) && !$stable(sda_pull)) |-> ($past(r_q.st) == ST_LOW_A)); // R4

    AST_HOLD_INSIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOW_A) |-> (r_q.len.dat_hold < r_q.len.low)); // R4

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) && !scl_pull) |-> ($past(r_q.st) == ST_IDLE)); // R5

    AST_STOP_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pull) && !scl_pull) |-> (r_q.st == ST_IDLE)); // R6

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOW_B || r_q.st == ST_HIGH) |-> $stable(r_q.len)); // R10

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2ct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] div_cfg,
    input  logic       start_req,
    input  logic       bit_req,
    input  logic       stop_req,
    input  logic       bit_val,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       op_done
);

    rate_entry_t entry;
    phase_len_t  lens;

    i2ct_rate_lut u_lut (
        .idx   (div_cfg[IDX_W-1:0]),
        .entry (entry)
    );

    i2ct_scale u_scale (
        .mul_code (div_cfg[7 -: MUL_W]),
        .entry    (entry),
        .lens     (lens)
    );

    i2ct_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .bit_req   (bit_req),
        .stop_req  (stop_req),
        .bit_val   (bit_val),
        .lens_in   (lens),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .done      (op_done)
    );

    AST_DONE_NEEDS_SCL_LOW_OR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (scl_pull || !sda_pull)); // R8

endmodule

// File: tb/tb_i2c_bit_timer.sv
`timescale 1ns/1ps
module tb_i2c_bit_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_cfg = 8'h00;
    logic       start_req = 1'b0, bit_req = 1'b0, stop_req = 1'b0, bit_val = 1'b0;
    logic       scl_pull, sda_pull, op_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    i2c_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg),
        .start_req(start_req), .bit_req(bit_req), .stop_req(stop_req), .bit_val(bit_val),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .op_done(op_done)
    );

    typedef struct {
        bit    scl;
        bit    sda;
        bit    dn;
        string tag;
    } exp_t;

    exp_t  exq[$];
    exp_t  cur;
    int    mode = 0;
    bit    line_sda = 0;

    // timing from the rate setting, per R2, R3, R4, R5, R6, R7
    task automatic calc(input logic [7:0] cfg, output int lo, output int hi,
                        output int dh, output int sh, output int ph);
        int f, d, a, s, p, per;
        f = (cfg[7:6] == 2'b01) ? 2 : (cfg[7:6] == 2'b10) ? 4 : 1;
        case (cfg[5:0])
            6'h07:   begin d = 40; a = 40; s = 68;  p = 82;  end
            6'h0B:   begin d = 40; a = 36; s = 64;  p = 84;  end
            6'h14:   begin d = 80; a = 68; s = 128; p = 168; end
            6'h18:   begin d = 80; a = 36; s = 96;  p = 176; end
            default: begin d = 20; a = 28; s = 38;  p = 41;  end
        endcase
        per = f * d;
        lo  = per / 2;
        hi  = per - lo;
        dh  = (f * a) / 4;
        if (dh < 1) dh = 1;
        if (dh > lo - 1) dh = lo - 1;
        sh = (f * s) / 4; if (sh < 1) sh = 1;
        ph = (f * p) / 4; if (ph < 1) ph = 1;
    endtask

    task automatic push(input bit c, input bit s, input bit dn, input string t, input int n);
        exp_t e;
        e.scl = c; e.sda = s; e.dn = dn; e.tag = t;
        for (int i = 0; i < n; i++) exq.push_back(e);
    endtask

    always @(posedge clk) begin
        int lo, hi, dh, sh, ph;
        bit ns;
        if (!rst_n) begin
            exq.delete();
            mode = 0; line_sda = 0;
            cur.scl = 0; cur.sda = 0; cur.dn = 0; cur.tag = "R1";
        end else begin
            if (exq.size() == 0) begin
                calc(div_cfg, lo, hi, dh, sh, ph);
                if (mode == 0 && start_req) begin
                    push(0, 1, 0, "R5", sh);
                    push(1, 1, 1, "R8", 1);
                    mode = 1; line_sda = 1;
                end else if (mode == 1 && (stop_req || bit_req)) begin
                    ns = stop_req ? 1'b1 : !bit_val;
                    push(1, line_sda, 0, "R4", dh);
                    push(1, ns, 0, stop_req ? "R6" : "R12", lo - dh);
                    if (stop_req) begin
                        push(0, 1, 0, "R6", ph);
                        push(0, 0, 1, "R8", 1);
                        mode = 0; line_sda = 0;
                    end else begin
                        push(0, ns, 0, "R3", hi);
                        push(1, ns, 1, "R8", 1);
                        line_sda = ns;
                    end
                end
            end
            if (exq.size() > 0) cur = exq.pop_front();
            else begin
                cur.scl = (mode == 1); cur.sda = line_sda; cur.dn = 0; cur.tag = "R9";
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (scl_pull !== cur.scl || sda_pull !== cur.sda || op_done !== cur.dn) begin
                errors++;
                $display("FAIL %s cycle %0d: scl/sda/done act %b%b%b exp %b%b%b",
                         cur.tag, cycles, scl_pull, sda_pull, op_done, cur.scl, cur.sda, cur.dn);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic req(input bit s, input bit b, input bit p, input bit v);
        @(negedge clk);
        start_req = s; bit_req = b; stop_req = p; bit_val = v;
        @(negedge clk);
        start_req = 0; bit_req = 0; stop_req = 0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!op_done);
    endtask

    // R11 measurements: START hold, data hold, STOP hold as run lengths
    task automatic measure(input logic [7:0] cfg, input int e_sta, input int e_dat, input int e_sto);
        int c;
        bit prev;
        div_cfg = cfg;
        req(1, 0, 0, 0);
        c = 0;
        while (!scl_pull) begin c++; @(negedge clk); end
        chk(c, e_sta, "R11 start hold");
        prev = sda_pull;
        req(0, 1, 0, 1);
        c = 0;
        while (sda_pull == prev) begin c++; @(negedge clk); end
        chk(c, e_dat, "R11 data hold");
        wait_done();
        req(0, 0, 1, 0);
        while (scl_pull) @(negedge clk);
        c = 0;
        while (!scl_pull && sda_pull) begin c++; @(negedge clk); end
        chk(c, e_sto, "R11 stop hold");
    endtask

    task automatic frame(input logic [7:0] cfg, input logic [3:0] bits);
        div_cfg = cfg;
        req(1, 0, 0, 0); wait_done();
        for (int i = 3; i >= 0; i--) begin
            req(0, 1, 0, bits[i]); wait_done();
        end
        req(0, 0, 1, 0); wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(scl_pull, 0, "R1 scl");
        chk(sda_pull, 0, "R1 sda");
        chk(op_done, 0, "R1 done");
        rst_n = 1'b1;
        @(negedge clk);

        // R9: bit and stop while idle are ignored
        req(0, 1, 0, 0);
        req(0, 0, 1, 0);
        repeat (3) @(negedge clk);
        chk(sda_pull, 0, "R9 idle sda");

        measure(8'h80, 38, 28, 41);   // R11
        measure(8'h18, 24, 9, 44);    // R11

        frame(8'h00, 4'b1010);        // R3 R12 factor 1
        frame(8'h58, 4'b0110);        // R2 factor 2
        frame(8'hC7, 4'b1001);        // R2 reserved code as factor 1
        frame(8'h0B, 4'b0011);        // R7
        frame(8'h94, 4'b1100);        // R7 factor 4
        frame(8'h05, 4'b0101);        // R7 unlisted index falls back

        // R10: rate write in the middle of a bit
        div_cfg = 8'h00;
        req(1, 0, 0, 0); wait_done();
        req(0, 1, 0, 0);
        repeat (3) @(negedge clk);
        div_cfg = 8'h80;
        // R9: start during a bit is ignored
        req(1, 0, 0, 0);
        wait_done();
        // R9: start while SCL held low is ignored
        req(1, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk(scl_pull, 1, "R9 start in park");
        // R9: bit and stop together, stop wins
        div_cfg = 8'h00;
        req(0, 1, 1, 1); wait_done();
        @(negedge clk);
        chk(scl_pull + sda_pull, 0, "R9 stop priority idle");

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: act %0d exp below 150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule